// File: doc/BRIEF.md
# External Memory Chip-Select Controller

This block sits between a processor's load/store port and a shared memory bus. The top address bits of each request choose one of several regions. Each region has a fixed device data width of 8, 16 or 32 bits, and its own programmable wait count. The controller pulls the matching active-low chip select low and runs one or more bus cycles. Each bus cycle is stretched by that region's wait states. The controller then returns a one-cycle done strobe, with read data assembled to the right width.

When a request is wider than the device behind the chosen select, the controller runs back-to-back narrower bus cycles, lowest address first. On 16-bit devices it drives separate active-low upper-byte and lower-byte enables, so that a byte write touches only its own lane. Select indices with no device behind them end at once with an error flag.

A requester issues one request at a time. It pulses `req` while the block is idle and waits for `done`. Requests must be aligned to their size. The default map is as follows: selects 0 to 3 are 16-bit, select 4 is 8-bit, select 6 is 32-bit, and selects 5 and 7 are unmapped.

Top module: `memcs_ctrl`

## Requirements
- R1: After reset, every chip select, `oe_n`, `we_n`, `ub_n` and `lb_n` is high, and `done` and `err` are low.
- R2: The select index is `req_addr[ADDR_W-1 -: IDX_W]`. During an access to a mapped region, only that region's chip select is low and all others stay high.
- R3: Each bus cycle keeps the chip select low for wait+1 clocks, where wait is the region's wait register. Every wait register resets to 3, which gives 4 clocks per bus cycle. `done` rises one clock after the last bus cycle ends.
- R4: Writing 0 to a region's wait register through `cfg_we`/`cfg_idx`/`cfg_wait` makes each of its bus cycles last a single clock.
- R5: A word request (`req_size`=2) to a 16-bit region runs two bus cycles. The first goes to the aligned address and carries bits 15:0. The second goes to address+2 and carries bits 31:16. Read data returns as {second[15:0], first[15:0]}.
- R6: A request to an 8-bit region wider than a byte runs one bus cycle per byte at successive addresses, starting with the lowest. Each cycle carries that byte on `bus_wdata[7:0]` or takes it from `bus_rdata[7:0]`, with `lb_n` low and `ub_n` high.
- R7: A byte request (`req_size`=0) to a 16-bit region drives the even address. The byte appears on both lanes of `bus_wdata[15:0]`. `lb_n` is low only for an even address, and `ub_n` is low only for an odd address. A read returns the addressed lane in `rdata[7:0]`.
- R8: A request to an unmapped index raises `done` and `err` together one clock after acceptance, and asserts no chip select.
- R9: A request to a 32-bit region is a single bus cycle on the word-aligned address. Sub-word data is shifted by the byte offset `req_addr[1:0]`.
- R10: A `req` pulse that arrives while an access is in progress is ignored. It starts no bus cycle, either during or after the current access.
- R11: `done` is a single-clock pulse per request, and `err` stays low for mapped regions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request pulse, taken when idle |
| req_addr | input | ADDR_W | Byte address; top IDX_W bits pick the region |
| req_we | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 half-word, 2 word |
| req_wdata | input | 32 | Write data, right-aligned |
| done | output | 1 | Completion strobe |
| err | output | 1 | Unmapped region flag, valid with done |
| rdata | output | 32 | Assembled read data, valid with done |
| cfg_we | input | 1 | Wait register write enable |
| cfg_idx | input | IDX_W | Wait register index |
| cfg_wait | input | WAIT_W | Wait value to store |
| cs_n | output | NUM_CS | Active-low chip selects |
| bus_addr | output | ADDR_W | Bus byte address |
| bus_wdata | output | 32 | Bus write data |
| bus_rdata | input | 32 | Bus read data |
| oe_n | output | 1 | Active-low output enable (reads) |
| we_n | output | 1 | Active-low write strobe |
| ub_n | output | 1 | Active-low upper byte enable |
| lb_n | output | 1 | Active-low lower byte enable |

## Verification
The hardest case to reach from the ports is a second request that arrives in the middle of a stretched, multi-beat access. If it were wrongly accepted, it would show up only as an extra select or a changed address several clocks later. The bench pulses `req` for another region during the second clock of a four-clock bus cycle. It then logs every clock on which a select is low, and watches the bus for several clocks after `done`. Split accesses are checked beat by beat against a bus model whose read data is a function of the bus address. This exposes both the beat order and any lane mistake in the assembled result.

// File: rtl/memcs_pkg.sv
package memcs_pkg;
  typedef enum logic [1:0] {
    WID8    = 2'd0,
    WID16   = 2'd1,
    WID32   = 2'd2,
    WIDNONE = 2'd3
  } wid_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_BUS  = 2'd1,
    S_DONE = 2'd2
  } st_e;
endpackage

// File: rtl/memcs_decode.sv
module memcs_decode
  import memcs_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int IDX_W  = 3,
  parameter logic [2*NUM_CS-1:0] WMAP = '1
) (
  input  logic [IDX_W-1:0] idx,
  output wid_e             wid,
  output logic             hit
);
  logic [1:0] codes [NUM_CS];

  genvar g;
  generate
    for (g = 0; g < NUM_CS; g++) begin : g_map
      assign codes[g] = WMAP[2*g +: 2];
    end
  endgenerate

  always_comb begin
    wid = WIDNONE;
    for (int i = 0; i < NUM_CS; i++)
      if (idx == IDX_W'(i)) wid = wid_e'(codes[i]);
  end

  assign hit = (wid != WIDNONE);
endmodule

// File: rtl/memcs_waits.sv
module memcs_waits #(
  parameter int NUM_CS   = 8,
  parameter int IDX_W    = 3,
  parameter int WAIT_W   = 4,
  parameter int DEF_WAIT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WAIT_W-1:0] wr_val,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WAIT_W-1:0] rd_val
);
  logic [WAIT_W-1:0] w_q [NUM_CS];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_CS; i++) begin
      if (rst) w_q[i] <= WAIT_W'(DEF_WAIT);
      else if (wr_en && wr_idx == IDX_W'(i)) w_q[i] <= wr_val;
    end
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NUM_CS; i++)
      if (rd_idx == IDX_W'(i)) rd_val = w_q[i];
  end
endmodule

// File: rtl/memcs_lanes.sv
module memcs_lanes
  import memcs_pkg::*;
(
  input  wid_e        wid,
  input  logic [1:0]  size,
  input  logic [1:0]  beat,
  input  logic [1:0]  alo,
  input  logic [31:0] wdata,
  input  logic [31:0] rd_bus,
  input  logic [31:0] acc,
  output logic [31:0] wd_bus,
  output logic        ub_n,
  output logic        lb_n,
  output logic [31:0] acc_nxt
);
  logic [4:0]  sh;
  logic [31:0] rd_sh;

  assign sh    = {alo, 3'b000};
  assign rd_sh = rd_bus >> sh;

  always_comb begin
    wd_bus  = '0;
    ub_n    = 1'b1;
    lb_n    = 1'b1;
    acc_nxt = acc;
    case (wid)
      WID8: begin
        wd_bus[7:0] = wdata[beat*8 +: 8];
        lb_n        = 1'b0;
        acc_nxt[beat*8 +: 8] = rd_bus[7:0];
      end
      WID16: begin
        if (size == 2'd0) begin
          wd_bus[15:0] = {wdata[7:0], wdata[7:0]};
          lb_n         = alo[0];
          ub_n         = ~alo[0];
          acc_nxt      = {24'd0, alo[0] ? rd_bus[15:8] : rd_bus[7:0]};
        end else begin
          wd_bus[15:0] = wdata[beat[0]*16 +: 16];
          lb_n         = 1'b0;
          ub_n         = 1'b0;
          acc_nxt[beat[0]*16 +: 16] = rd_bus[15:0];
        end
      end
      WID32: begin
        wd_bus = wdata << sh;
        lb_n   = 1'b0;
        ub_n   = 1'b0;
        case (size)
          2'd0:    acc_nxt = {24'd0, rd_sh[7:0]};
          2'd1:    acc_nxt = {16'd0, rd_sh[15:0]};
          default: acc_nxt = rd_sh;
        endcase
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/memcs_ctrl.sv
module memcs_ctrl
  import memcs_pkg::*;
#(
  parameter int NUM_CS   = 8,
  parameter int ADDR_W   = 24,
  parameter int WAIT_W   = 4,
  parameter int DEF_WAIT = 3,
  parameter logic [2*NUM_CS-1:0] WMAP = 16'hEC55
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic                      req_we,
  input  logic [1:0]                req_size,
  input  logic [31:0]               req_wdata,
  output logic                      done,
  output logic                      err,
  output logic [31:0]               rdata,
  input  logic                      cfg_we,
  input  logic [$clog2(NUM_CS)-1:0] cfg_idx,
  input  logic [WAIT_W-1:0]         cfg_wait,
  output logic [NUM_CS-1:0]         cs_n,
  output logic [ADDR_W-1:0]         bus_addr,
  output logic [31:0]               bus_wdata,
  input  logic [31:0]               bus_rdata,
  output logic                      oe_n,
  output logic                      we_n,
  output logic                      ub_n,
  output logic                      lb_n
);
  localparam int IDX_W = $clog2(NUM_CS);

  st_e               state_q;
  logic [IDX_W-1:0]  idx_q;
  wid_e              wid_q;
  logic [1:0]        size_q;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [31:0]       wdata_q;
  logic [1:0]        beat_q, last_q;
  logic [WAIT_W-1:0] cnt_q, wait_q;
  logic [31:0]       acc_q;

  logic [IDX_W-1:0]  idx_in;
  wid_e              wid_in;
  logic              hit_in;
  logic [WAIT_W-1:0] wait_in;
  logic [1:0]        last_in;
  logic [31:0]       acc_nxt, lane_wd;
  logic              lane_ub_n, lane_lb_n;
  logic              in_bus;

  assign idx_in = req_addr[ADDR_W-1 -: IDX_W];
  assign in_bus = (state_q == S_BUS);

  memcs_decode #(.NUM_CS(NUM_CS), .IDX_W(IDX_W), .WMAP(WMAP)) u_dec (
    .idx(idx_in), .wid(wid_in), .hit(hit_in)
  );

  memcs_waits #(.NUM_CS(NUM_CS), .IDX_W(IDX_W), .WAIT_W(WAIT_W), .DEF_WAIT(DEF_WAIT)) u_waits (
    .clk(clk), .rst(rst), .wr_en(cfg_we), .wr_idx(cfg_idx), .wr_val(cfg_wait),
    .rd_idx(idx_in), .rd_val(wait_in)
  );

  memcs_lanes u_lanes (
    .wid(wid_q), .size(size_q), .beat(beat_q), .alo(addr_q[1:0]),
    .wdata(wdata_q), .rd_bus(bus_rdata), .acc(acc_q),
    .wd_bus(lane_wd), .ub_n(lane_ub_n), .lb_n(lane_lb_n), .acc_nxt(acc_nxt)
  );

  // number of bus cycles minus one for the incoming request
  always_comb begin
    last_in = 2'd0;
    if (wid_in == WID8) begin
      if (req_size == 2'd1)      last_in = 2'd1;
      else if (req_size >= 2'd2) last_in = 2'd3;
    end else if (wid_in == WID16 && req_size >= 2'd2) begin
      last_in = 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      wid_q   <= WIDNONE;
      size_q  <= '0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      beat_q  <= '0;
      last_q  <= '0;
      cnt_q   <= '0;
      wait_q  <= '0;
      acc_q   <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
      rdata   <= '0;
    end else begin
      case (state_q)
        S_IDLE: begin
          done <= 1'b0;
          err  <= 1'b0;
          if (req) begin
            if (!hit_in) begin
              state_q <= S_DONE;
              done    <= 1'b1;
              err     <= 1'b1;
              rdata   <= '0;
            end else begin
              state_q <= S_BUS;
              idx_q   <= idx_in;
              wid_q   <= wid_in;
              size_q  <= req_size;
              we_q    <= req_we;
              addr_q  <= req_addr;
              wdata_q <= req_wdata;
              beat_q  <= '0;
              last_q  <= last_in;
              cnt_q   <= wait_in;
              wait_q  <= wait_in;
              acc_q   <= '0;
            end
          end
        end
        S_BUS: begin
          if (cnt_q == '0) begin
            acc_q <= acc_nxt;
            if (beat_q == last_q) begin
              state_q <= S_DONE;
              done    <= 1'b1;
              rdata   <= acc_nxt;
            end else begin
              beat_q <= beat_q + 2'd1;
              cnt_q  <= wait_q;
            end
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: begin
          done    <= 1'b0;
          err     <= 1'b0;
          state_q <= S_IDLE;
        end
      endcase
    end
  end

  // bus side driven from the registered access state
  always_comb begin
    cs_n = '1;
    if (in_bus) cs_n[idx_q] = 1'b0;
    case (wid_q)
      WID8:    bus_addr = addr_q + ADDR_W'(beat_q);
      WID16:   bus_addr = (addr_q & ~ADDR_W'(1)) + ADDR_W'({beat_q, 1'b0});
      default: bus_addr = addr_q & ~ADDR_W'(3);
    endcase
    bus_wdata = lane_wd;
    oe_n = ~(in_bus & ~we_q);
    we_n = ~(in_bus & we_q);
    ub_n = in_bus ? lane_ub_n : 1'b1;
    lb_n = in_bus ? lane_lb_n : 1'b1;
  end

  // R2: never more than one select low
  a_r2_one_select: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n));
  // R8: error completion carries no select
  a_r8_err_no_cs: assert property (@(posedge clk) disable iff (rst)
    err |-> (done && (&cs_n)));
  // R11: completion strobe lasts one clock
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R3: wait counter stays within the latched wait value
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    in_bus |-> (cnt_q <= wait_q));
  // R5: beat number never passes the planned beat count
  a_r5_beat_bound: assert property (@(posedge clk) disable iff (rst)
    in_bus |-> (beat_q <= last_q));
  // R10: target region held for the whole access
  a_r10_idx_stable: assert property (@(posedge clk) disable iff (rst)
    (in_bus && $past(in_bus)) |-> $stable(idx_q));
endmodule

// File: tb/tb_memcs_ctrl.sv
`timescale 1ns/1ps
module tb_memcs_ctrl;
  logic        clk = 1'b0;
  logic        rst;
  logic        req = 1'b0;
  logic [23:0] req_addr = '0;
  logic        req_we = 1'b0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        done, err;
  logic [31:0] rdata;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [3:0]  cfg_wait = '0;
  logic [7:0]  cs_n;
  logic [23:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        oe_n, we_n, ub_n, lb_n;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  memcs_ctrl dut (
    .clk(clk), .rst(rst), .req(req), .req_addr(req_addr), .req_we(req_we),
    .req_size(req_size), .req_wdata(req_wdata), .done(done), .err(err), .rdata(rdata),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wait(cfg_wait), .cs_n(cs_n),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .oe_n(oe_n), .we_n(we_n), .ub_n(ub_n), .lb_n(lb_n)
  );

  function automatic logic [7:0] fb(input logic [23:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  function automatic logic [31:0] fw(input logic [23:0] a);
    return {fb(a + 24'd3), fb(a + 24'd2), fb(a + 24'd1), fb(a)};
  endfunction

  function automatic logic [23:0] mk(input logic [2:0] idx, input logic [20:0] off);
    return {idx, off};
  endfunction

  assign bus_rdata = fw(bus_addr);

  // bus log
  logic [7:0]  lg_cs   [64];
  logic [23:0] lg_addr [64];
  logic [31:0] lg_wd   [64];
  logic        lg_oe   [64];
  logic        lg_we   [64];
  logic        lg_ub   [64];
  logic        lg_lb   [64];
  int lg_n = 0;

  always @(negedge clk) begin
    if (!rst && cs_n != 8'hFF && lg_n < 64) begin
      lg_cs[lg_n]   <= cs_n;
      lg_addr[lg_n] <= bus_addr;
      lg_wd[lg_n]   <= bus_wdata;
      lg_oe[lg_n]   <= oe_n;
      lg_we[lg_n]   <= we_n;
      lg_ub[lg_n]   <= ub_n;
      lg_lb[lg_n]   <= lb_n;
      lg_n <= lg_n + 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_wait(input logic [2:0] idx, input logic [3:0] w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_wait = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic access(input logic [23:0] a, input logic [1:0] sz, input logic wr,
                        input logic [31:0] wd, output int lat);
    @(negedge clk);
    lg_n = 0;
    req = 1'b1; req_addr = a; req_size = sz; req_we = wr; req_wdata = wd;
    lat = 0;
    do begin
      @(negedge clk);
      req = 1'b0;
      lat++;
    end while (!done && lat < 200);
  endtask

  task automatic t_reset;
    check("R1 cs_n", 32'(cs_n), 32'hFF);
    check("R1 strobes", {28'd0, oe_n, we_n, ub_n, lb_n}, 32'hF);
    check("R1 done/err", {30'd0, done, err}, 32'd0);
  endtask

  task automatic t_half_read_wait3;
    int lat;
    logic [23:0] a = mk(3'd0, 21'h000120);
    access(a, 2'd1, 1'b0, 32'd0, lat);
    check("R3 latency", lat, 5);
    check("R3 cycle count", lg_n, 4);
    check("R2 select", 32'(lg_cs[0]), 32'hFE);
    check("R2 select held", 32'(lg_cs[3]), 32'hFE);
    check("R3 oe_n", 32'(lg_oe[0]), 0);
    check("R3 rdata", rdata, {16'd0, fb(a + 24'd1), fb(a)});
    check("R11 err low", 32'(err), 0);
    @(negedge clk);
    check("R11 done pulse", 32'(done), 0);
  endtask

  task automatic t_word_read_16;
    int lat;
    logic [23:0] a = mk(3'd1, 21'h000200);
    access(a, 2'd2, 1'b0, 32'd0, lat);
    check("R5 latency", lat, 9);
    check("R5 cycle count", lg_n, 8);
    check("R5 first addr", lg_addr[0], a);
    check("R5 second addr", lg_addr[4], a + 24'd2);
    check("R5 select", 32'(lg_cs[7]), 32'hFD);
    check("R5 rdata", rdata, fw(a));
  endtask

  task automatic t_word_write_16;
    int lat;
    logic [23:0] a = mk(3'd2, 21'h000040);
    access(a, 2'd2, 1'b1, 32'hDEADBEEF, lat);
    check("R5 wr count", lg_n, 8);
    check("R5 wr low half", {lg_addr[0][7:0], lg_wd[0][15:0]}, {a[7:0], 16'hBEEF});
    check("R5 wr high half", {lg_addr[4][7:0], lg_wd[4][15:0]}, {a[7:0] + 8'd2, 16'hDEAD});
    check("R5 wr strobes", {lg_we[0], lg_oe[0], lg_ub[0], lg_lb[0]}, 32'b0100);
  endtask

  task automatic t_byte_region;
    int lat;
    logic [23:0] a = mk(3'd4, 21'h000310);
    set_wait(3'd4, 4'd1);
    access(a, 2'd1, 1'b1, 32'h00001234, lat);
    check("R6 latency", lat, 5);
    check("R6 count", lg_n, 4);
    check("R6 beat0", {lg_addr[0], lg_wd[0][7:0]}, {a, 8'h34});
    check("R6 beat1", {lg_addr[2], lg_wd[2][7:0]}, {a + 24'd1, 8'h12});
    check("R6 lanes", {lg_ub[0], lg_lb[0]}, 32'b10);
    access(a, 2'd2, 1'b0, 32'd0, lat);
    check("R6 word count", lg_n, 8);
    check("R6 fourth addr", lg_addr[6], a + 24'd3);
    check("R6 word rdata", rdata, {fb(a + 24'd3), fb(a + 24'd2), fb(a + 24'd1), fb(a)});
  endtask

  task automatic t_byte_lanes;
    int lat;
    logic [23:0] ao = mk(3'd3, 21'h000051);
    logic [23:0] ae = mk(3'd3, 21'h000050);
    access(ao, 2'd0, 1'b1, 32'h000000C3, lat);
    check("R7 odd count", lg_n, 4);
    check("R7 odd addr", lg_addr[0], ae);
    check("R7 odd lanes", {lg_ub[0], lg_lb[0]}, 32'b01);
    check("R7 odd data", lg_wd[0][15:0], 16'hC3C3);
    access(ae, 2'd0, 1'b1, 32'h0000007E, lat);
    check("R7 even lanes", {lg_ub[0], lg_lb[0]}, 32'b10);
    check("R7 even data", lg_wd[0][15:0], 16'h7E7E);
    access(ao, 2'd0, 1'b0, 32'd0, lat);
    check("R7 odd read", rdata, {24'd0, fb(ao)});
  endtask

  task automatic t_wide_region;
    int lat;
    logic [23:0] a = mk(3'd6, 21'h000480);
    set_wait(3'd6, 4'd0);
    access(a, 2'd2, 1'b0, 32'd0, lat);
    check("R4 latency", lat, 2);
    check("R4 count", lg_n, 1);
    check("R9 word rdata", rdata, fw(a));
    access(a + 24'd2, 2'd0, 1'b0, 32'd0, lat);
    check("R9 addr aligned", lg_addr[0], a);
    check("R9 byte rdata", rdata, {24'd0, fb(a + 24'd2)});
    access(a + 24'd2, 2'd1, 1'b1, 32'h0000A55A, lat);
    check("R9 half write shift", lg_wd[0], 32'hA55A0000);
  endtask

  task automatic t_unmapped;
    int lat;
    access(mk(3'd5, 21'h000010), 2'd1, 1'b0, 32'd0, lat);
    check("R8 latency", lat, 1);
    check("R8 err", 32'(err), 1);
    check("R8 no select", lg_n, 0);
    access(mk(3'd7, 21'h000000), 2'd2, 1'b1, 32'h1, lat);
    check("R8 idx7 err", {30'd0, err, done}, 32'b11);
    check("R8 idx7 no select", lg_n, 0);
  endtask

  task automatic t_busy_ignore;
    int lat;
    int extra;
    logic [23:0] a = mk(3'd0, 21'h000600);
    @(negedge clk);
    lg_n = 0;
    req = 1'b1; req_addr = a; req_size = 2'd1; req_we = 1'b0;
    @(negedge clk);
    req = 1'b0;
    @(negedge clk);
    req = 1'b1; req_addr = mk(3'd1, 21'h000700);
    @(negedge clk);
    req = 1'b0;
    lat = 3;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    check("R10 latency", lat, 5);
    check("R10 count", lg_n, 4);
    check("R10 select", 32'(lg_cs[3]), 32'hFE);
    extra = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (cs_n != 8'hFF || done) extra++;
    end
    check("R10 no later access", extra, 0);
  endtask

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_half_read_wait3();
    t_word_read_16();
    t_word_write_16();
    t_byte_region();
    t_byte_lanes();
    t_wide_region();
    t_unmapped();
    t_busy_ignore();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule